// File: doc/BRIEF.md
# Parallel EEPROM Page Write Controller

This block is the host side of a parallel byte-wide EEPROM write. On a start request it takes up to 64 bytes from a byte stream and loads them into the memory one byte-load cycle at a time. All the bytes land in a single page, and the loads follow each other closely enough that the memory does not start programming before the last one. Once the last byte is loaded, the controller releases the data bus and reads the last written address over and over. It stops when the memory shows that internal programming is over, so it does not wait out a fixed worst-case delay.

An input picks one of two completion tests. In the first, the controller waits until bit 7 of the read equals bit 7 of the last byte written. In the second, it waits until bit 6 holds the same value on two reads in a row. Every strobe width and limit is a parameter counted in clock cycles. The byte source is a valid/ready stream. The controller raises ready only while it waits for its next byte, and a source may hold valid low for a while. If the source stalls for so long that the next load could not start inside the load window, the operation is abandoned with an error pulse. The start, busy, done and error pins are plain levels and pulses.

Top module: `epw_page_writer`

## Requirements
- R1: After reset and whenever `busy` is low, `mem_cs_n`, `mem_wr_n` and `mem_rd_n` are high and `mem_dq_drive` is low.
- R2: An accepted start writes `len_m1`+1 bytes, taking exactly one stream byte per valid/ready handshake, in stream order. Byte i goes to the address whose bits [14:6] equal those of `base_addr` and whose bits [5:0] are (`base_addr[5:0]` + i) mod 64.
- R3: While `mem_wr_n` is low, `mem_cs_n` is low, `mem_rd_n` is high and `mem_dq_drive` is high. Each write strobe stays low for exactly PULSE_CYC cycles.
- R4: Consecutive `mem_wr_n` falling edges within one operation are at most WINDOW_CYC cycles apart. If the stream has not delivered the next byte in time, the operation ends with an `err` pulse, no `done` pulse and no further write strobe.
- R5: `mem_dq_drive` is low whenever `mem_rd_n` is low, and it is low in the cycle before every falling edge of `mem_rd_n`.
- R6: With `poll_toggle`=0, the controller reads the last written address until read bit 7 (`mem_stat_in[1]`) equals bit 7 of the last byte written, then pulses `done`.
- R7: With `poll_toggle`=1, the controller reads the last written address until two consecutive reads return the same bit 6 (`mem_stat_in[0]`), then pulses `done`.
- R8: Each read strobe holds `mem_rd_n` low for exactly READ_CYC cycles, and `mem_rd_n` then returns high.
- R9: If completion has not been seen POLL_TIMEOUT cycles after the polling phase begins, the controller pulses `err`, does not pulse `done`, and returns to idle.
- R10: `busy` rises in the cycle after an accepted start. A start while busy is ignored. `done` and `err` are one-cycle pulses that are never high together, and `busy` is low in the cycle where either is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start request, taken only when idle |
| base_addr | input | ADDR_W | Address of the first byte; bits [14:6] select the page |
| len_m1 | input | PAGE_W | Byte count minus one |
| poll_toggle | input | 1 | 0: bit-7 compare polling, 1: bit-6 stability polling |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse on detected completion |
| err | output | 1 | One-cycle pulse on stream starvation or poll timeout |
| src_valid | input | 1 | Stream byte available |
| src_ready | output | 1 | Controller takes the byte this cycle if valid |
| src_data | input | 8 | Stream byte |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_out | output | 8 | Write data toward the memory |
| mem_dq_drive | output | 1 | Enable of the data bus driver |
| mem_stat_in | input | 2 | Data bus bits 7 and 6 read from the memory |
| mem_cs_n | output | 1 | Memory select, active low |
| mem_wr_n | output | 1 | Write strobe, active low |
| mem_rd_n | output | 1 | Read (output) enable, active low |

## Verification
The bound checker watches the strobe rules on every cycle: write and read strobes never overlap, the write pulse and read pulse widths are exact, the load spacing stays inside the window, every write stays in the page taken at start, the bus driver is released before each read, and the done and error pulses keep their shape. Only the bench's scenarios can show that the right bytes reach the right addresses, that completion comes promptly after the memory finishes programming in both polling modes and never before, that a stalled stream or a memory that never finishes leads to an error, and that a second start during an operation has no effect on the memory.

// File: rtl/epw_pkg.sv
package epw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_SETUP,
    ST_PULSE,
    ST_HOLD,
    ST_TURN,
    ST_READ,
    ST_GAP
  } epw_state_e;

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/epw_cycle_counter.sv
module epw_cycle_counter #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  output logic [WIDTH-1:0] count
);
  // Saturating up-counter, restarted by clear.
  always_ff @(posedge clk) begin
    if (!rst_n || clear) count <= '0;
    else if (count != {WIDTH{1'b1}}) count <= count + 1'b1;
  end
endmodule

// File: rtl/epw_page_addr.sv
module epw_page_addr #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic [PAGE_W-1:0] len_m1,
  input  logic              advance,
  output logic [ADDR_W-1:0] addr,
  output logic              last
);
  logic [ADDR_W-PAGE_W-1:0] page_hi;
  logic [PAGE_W-1:0]        offs;
  logic [PAGE_W-1:0]        left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_hi <= '0;
      offs    <= '0;
      left    <= '0;
    end else if (load) begin
      page_hi <= base[ADDR_W-1:PAGE_W];
      offs    <= base[PAGE_W-1:0];
      left    <= len_m1;
    end else if (advance) begin
      offs <= offs + 1'b1;   // wraps inside the page
      left <= left - 1'b1;
    end
  end

  assign addr = {page_hi, offs};
  assign last = (left == '0);
endmodule

// File: rtl/epw_poll_eval.sv
module epw_poll_eval (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       toggle_mode,
  input  logic       sample,
  input  logic [1:0] stat,       // [1] = bus bit 7, [0] = bus bit 6
  input  logic       want_bit7,
  output logic       complete
);
  logic prev_b6;
  logic have_prev;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      prev_b6   <= 1'b0;
      have_prev <= 1'b0;
      complete  <= 1'b0;
    end else if (sample) begin
      prev_b6   <= stat[0];
      have_prev <= 1'b1;
      if (toggle_mode) complete <= have_prev && (prev_b6 == stat[0]);
      else             complete <= (stat[1] == want_bit7);
    end
  end
endmodule

// File: rtl/epw_page_writer.sv
module epw_page_writer
  import epw_pkg::*;
#(
  parameter int unsigned ADDR_W       = 15,
  parameter int unsigned PAGE_W       = 6,
  parameter int unsigned SETUP_CYC    = 2,
  parameter int unsigned PULSE_CYC    = 4,
  parameter int unsigned HOLD_CYC     = 1,
  parameter int unsigned READ_CYC     = 3,
  parameter int unsigned WINDOW_CYC   = 12500,
  parameter int unsigned POLL_TIMEOUT = 1500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [PAGE_W-1:0] len_m1,
  input  logic              poll_toggle,
  output logic              busy,
  output logic              done,
  output logic              err,
  input  logic              src_valid,
  output logic              src_ready,
  input  logic [7:0]        src_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_dq_out,
  output logic              mem_dq_drive,
  input  logic [1:0]        mem_stat_in,
  output logic              mem_cs_n,
  output logic              mem_wr_n,
  output logic              mem_rd_n
);
  localparam int unsigned PH_MAX    = max4(SETUP_CYC, PULSE_CYC, HOLD_CYC, READ_CYC);
  localparam int unsigned PH_W      = $clog2(PH_MAX + 1);
  localparam int unsigned GAP_W     = $clog2(WINDOW_CYC + 1);
  localparam int unsigned TO_W      = $clog2(POLL_TIMEOUT + 1);
  localparam int unsigned STARVE_AT = WINDOW_CYC - SETUP_CYC - 1;

  epw_state_e        state, state_nx;
  logic [7:0]        wdata;
  logic              mode_tog;
  logic              have_fall;
  logic [PH_W-1:0]   ph_cnt;
  logic [GAP_W-1:0]  gap_cnt;
  logic [TO_W-1:0]   poll_cnt;
  logic              phase_last, starve, timed_out, complete, last_byte;
  logic              ph_clear, gap_clear, poll_clear;
  logic              take, accept, advance;

  epw_cycle_counter #(.WIDTH(PH_W))  u_phase (.clk(clk), .rst_n(rst_n), .clear(ph_clear),   .count(ph_cnt));
  epw_cycle_counter #(.WIDTH(GAP_W)) u_gap   (.clk(clk), .rst_n(rst_n), .clear(gap_clear),  .count(gap_cnt));
  epw_cycle_counter #(.WIDTH(TO_W))  u_poll  (.clk(clk), .rst_n(rst_n), .clear(poll_clear), .count(poll_cnt));

  epw_page_addr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(accept), .base(base_addr), .len_m1(len_m1),
    .advance(advance), .addr(mem_addr), .last(last_byte)
  );

  epw_poll_eval u_eval (
    .clk(clk), .rst_n(rst_n), .clear(state == ST_TURN), .toggle_mode(mode_tog),
    .sample((state == ST_READ) && phase_last), .stat(mem_stat_in),
    .want_bit7(wdata[7]), .complete(complete)
  );

  always_comb begin
    unique case (state)
      ST_SETUP: phase_last = (ph_cnt == PH_W'(SETUP_CYC - 1));
      ST_PULSE: phase_last = (ph_cnt == PH_W'(PULSE_CYC - 1));
      ST_HOLD:  phase_last = (ph_cnt == PH_W'(HOLD_CYC - 1));
      ST_READ:  phase_last = (ph_cnt == PH_W'(READ_CYC - 1));
      default:  phase_last = 1'b0;
    endcase
  end

  assign starve    = have_fall && (gap_cnt >= GAP_W'(STARVE_AT));
  assign timed_out = (poll_cnt >= TO_W'(POLL_TIMEOUT));
  assign src_ready = (state == ST_FETCH) && !starve;
  assign take      = src_ready && src_valid;
  assign accept    = (state == ST_IDLE) && start;
  assign advance   = (state == ST_HOLD) && phase_last && !last_byte;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (start) state_nx = ST_FETCH;
      ST_FETCH: if (starve) state_nx = ST_IDLE;
                else if (src_valid) state_nx = ST_SETUP;
      ST_SETUP: if (phase_last) state_nx = ST_PULSE;
      ST_PULSE: if (phase_last) state_nx = ST_HOLD;
      ST_HOLD:  if (phase_last) state_nx = last_byte ? ST_TURN : ST_FETCH;
      ST_TURN:  state_nx = ST_READ;
      ST_READ:  if (phase_last) state_nx = ST_GAP;
      ST_GAP:   state_nx = (complete || timed_out) ? ST_IDLE : ST_READ;
      default:  state_nx = ST_IDLE;
    endcase
  end

  assign ph_clear   = (state_nx != state);
  assign gap_clear  = (state == ST_SETUP) && phase_last;
  assign poll_clear = (state == ST_HOLD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      wdata     <= '0;
      mode_tog  <= 1'b0;
      have_fall <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      state <= state_nx;
      done  <= (state == ST_GAP) && complete;
      err   <= ((state == ST_FETCH) && starve) ||
               ((state == ST_GAP) && !complete && timed_out);
      if (accept) begin
        mode_tog  <= poll_toggle;
        have_fall <= 1'b0;
      end
      if (gap_clear) have_fall <= 1'b1;
      if (take) wdata <= src_data;
    end
  end

  assign busy         = (state != ST_IDLE);
  assign mem_dq_out   = wdata;
  assign mem_dq_drive = (state == ST_SETUP) || (state == ST_PULSE) || (state == ST_HOLD);
  assign mem_cs_n     = !(mem_dq_drive || (state == ST_READ));
  assign mem_wr_n     = (state != ST_PULSE);
  assign mem_rd_n     = (state != ST_READ);
endmodule

// File: rtl/epw_checker.sv
module epw_checker #(
  parameter int unsigned ADDR_W     = 15,
  parameter int unsigned PAGE_W     = 6,
  parameter int unsigned PULSE_CYC  = 4,
  parameter int unsigned READ_CYC   = 3,
  parameter int unsigned WINDOW_CYC = 12500
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     start,
  input logic [ADDR_W-PAGE_W-1:0] base_page,
  input logic                     busy,
  input logic                     done,
  input logic                     err,
  input logic [ADDR_W-1:0]        mem_addr,
  input logic                     mem_dq_drive,
  input logic                     mem_cs_n,
  input logic                     mem_wr_n,
  input logic                     mem_rd_n
);
  logic [15:0]              wr_low_run, rd_low_run;
  logic [31:0]              space_cnt;
  logic                     space_armed, prev_wr;
  logic [ADDR_W-PAGE_W-1:0] page_q;
  logic                     wr_fall;

  assign wr_fall = prev_wr && !mem_wr_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_low_run  <= '0;
      rd_low_run  <= '0;
      space_cnt   <= '0;
      space_armed <= 1'b0;
      prev_wr     <= 1'b1;
      page_q      <= '0;
    end else begin
      prev_wr    <= mem_wr_n;
      wr_low_run <= mem_wr_n ? 16'd0 : wr_low_run + 16'd1;
      rd_low_run <= mem_rd_n ? 16'd0 : rd_low_run + 16'd1;
      if (start && !busy) page_q <= base_page;
      if (!busy) begin
        space_armed <= 1'b0;
        space_cnt   <= '0;
      end else if (wr_fall) begin
        space_armed <= 1'b1;
        space_cnt   <= 32'd1;
      end else if (space_cnt != 32'hFFFF_FFFF) begin
        space_cnt <= space_cnt + 32'd1;
      end
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mem_cs_n && mem_wr_n && mem_rd_n && !mem_dq_drive)); // R1
  AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wr_n |-> (mem_addr[ADDR_W-1:PAGE_W] == page_q)); // R2
  AST_WRITE_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wr_n |-> (!mem_cs_n && mem_rd_n && mem_dq_drive)); // R3
  AST_WRITE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wr_n) |-> (wr_low_run == 16'(PULSE_CYC))); // R3
  AST_LOAD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fall && space_armed) |-> (space_cnt <= 32'(WINDOW_CYC))); // R4
  AST_BUS_FREE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rd_n |-> !mem_dq_drive); // R5
  AST_BUS_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_rd_n) |-> !$past(mem_dq_drive)); // R5
  AST_READ_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_rd_n) |-> (rd_low_run == 16'(READ_CYC))); // R8
  AST_READ_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rd_n |-> (rd_low_run < 16'(READ_CYC))); // R8
  AST_END_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err)); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err); // R9
  AST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |-> !busy); // R10
  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start)); // R10
endmodule

bind epw_page_writer epw_checker #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .PULSE_CYC(PULSE_CYC),
  .READ_CYC(READ_CYC), .WINDOW_CYC(WINDOW_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .base_page(base_addr[ADDR_W-1:PAGE_W]),
  .busy(busy), .done(done), .err(err), .mem_addr(mem_addr),
  .mem_dq_drive(mem_dq_drive), .mem_cs_n(mem_cs_n), .mem_wr_n(mem_wr_n),
  .mem_rd_n(mem_rd_n)
);

// File: tb/epw_page_writer_test.sv
module epw_page_writer_test;
  localparam int SETUP = 2, PULSE = 3, HOLD = 1, READ = 2, WIN = 24, TMO = 600;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, poll_toggle = 1'b0;
  logic [14:0] base_addr = '0;
  logic [5:0]  len_m1 = '0;
  logic busy, done, err, src_valid, src_ready;
  logic [7:0]  src_data, mem_dq_out;
  logic [14:0] mem_addr;
  logic mem_dq_drive, mem_cs_n, mem_wr_n, mem_rd_n;
  logic [1:0]  mem_stat_in;

  always #4 clk = ~clk;   // 125 MHz

  epw_page_writer #(.SETUP_CYC(SETUP), .PULSE_CYC(PULSE), .HOLD_CYC(HOLD),
    .READ_CYC(READ), .WINDOW_CYC(WIN), .POLL_TIMEOUT(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr), .len_m1(len_m1),
    .poll_toggle(poll_toggle), .busy(busy), .done(done), .err(err),
    .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_drive(mem_dq_drive),
    .mem_stat_in(mem_stat_in), .mem_cs_n(mem_cs_n), .mem_wr_n(mem_wr_n), .mem_rd_n(mem_rd_n));

  int checks = 0, fails = 0;
  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // byte source
  logic [7:0] src_bytes [64];
  int src_len = 0, src_idx = 0, stall_at = 99;
  logic src_on = 1'b0;
  assign src_valid = src_on && (src_idx < src_len) && (src_idx != stall_at);
  assign src_data  = src_bytes[src_idx[5:0]];
  always @(posedge clk) if (src_valid && src_ready) src_idx <= src_idx + 1;

  // memory model and monitors
  logic [7:0]  mem [1024];
  logic [14:0] buf_a [64];
  logic [7:0]  buf_d [64];
  int page_cnt = 0, prog_len = 50, prog_left = 0, gap_since = 0;
  logic programming = 1'b0, tog = 1'b0, model_kill = 1'b0;
  logic prev_wr = 1'b1, prev_rd = 1'b1, prev_drive = 1'b0;
  logic [8:0]  page_up = '0;
  logic [7:0]  last_data = '0;
  logic [14:0] last_addr = '0;
  longint cyc = 0, prog_end_cyc = 0, done_cyc = 0, err_cyc = 0, last_fall_cyc = 0;
  int writes = 0, done_n = 0, err_n = 0, max_space = 0, viol_page = 0, viol_bus = 0;
  int viol_wrprog = 0, viol_overlap = 0, viol_poll_addr = 0;
  int wr_run = 0, rd_run = 0, wr_min = 99, wr_max = 0, rd_min = 99, rd_max = 0;
  bit fall_seen = 0;

  assign mem_stat_in = (programming || page_cnt != 0) ? {~last_data[7], tog}
                                                      : mem[mem_addr[9:0]][7:6];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      for (int k = 0; k < 1024; k++) mem[k] <= 8'hFF;
      programming <= 1'b0; page_cnt <= 0; gap_since <= 0;
    end else if (model_kill) begin
      programming <= 1'b0; page_cnt <= 0;
    end else begin
      prev_wr <= mem_wr_n; prev_rd <= mem_rd_n; prev_drive <= mem_dq_drive;
      if (prev_wr && !mem_wr_n) begin
        if (programming) viol_wrprog++;
        if (page_cnt != 0 && mem_addr[14:6] != page_up) viol_page++;
        if (page_cnt == 0) page_up <= mem_addr[14:6];
        gap_since <= 0;
        if (fall_seen && int'(cyc - last_fall_cyc) > max_space) max_space = int'(cyc - last_fall_cyc);
        last_fall_cyc = cyc; fall_seen = 1;
      end else if (gap_since < 100000) gap_since <= gap_since + 1;
      if (!prev_wr && mem_wr_n && page_cnt < 64) begin
        buf_a[page_cnt] <= mem_addr; buf_d[page_cnt] <= mem_dq_out;
        page_cnt <= page_cnt + 1; last_data <= mem_dq_out; last_addr <= mem_addr;
        writes++;
      end
      if (!programming && page_cnt != 0 && (gap_since == WIN || !mem_rd_n)) begin
        programming <= 1'b1; prog_left <= prog_len;
      end
      if (programming) begin
        if (prog_left <= 1) begin
          for (int k = 0; k < 64; k++) if (k < page_cnt) mem[buf_a[k][9:0]] <= buf_d[k];
          page_cnt <= 0; programming <= 1'b0; prog_end_cyc <= cyc;
        end else prog_left <= prog_left - 1;
      end
      if (!prev_rd && mem_rd_n) tog <= ~tog;
      if (!mem_rd_n && mem_dq_drive) viol_bus++;
      if (prev_rd && !mem_rd_n && prev_drive) viol_bus++;
      if (!mem_rd_n && !mem_wr_n) viol_overlap++;
      if (!mem_rd_n && mem_addr != last_addr) viol_poll_addr++;
      if (!mem_wr_n) wr_run++;
      else if (wr_run != 0) begin
        if (wr_run < wr_min) wr_min = wr_run;
        if (wr_run > wr_max) wr_max = wr_run;
        wr_run = 0;
      end
      if (!mem_rd_n) rd_run++;
      else if (rd_run != 0) begin
        if (rd_run < rd_min) rd_min = rd_run;
        if (rd_run > rd_max) rd_max = rd_run;
        rd_run = 0;
      end
      if (done) begin done_n++; done_cyc = cyc; end
      if (err) begin err_n++; err_cyc = cyc; end
    end
  end

  task automatic clear_stats();
    writes = 0; done_n = 0; err_n = 0; max_space = 0; fall_seen = 0;
    viol_page = 0; viol_bus = 0; viol_wrprog = 0; viol_overlap = 0; viol_poll_addr = 0;
    wr_min = 99; wr_max = 0; rd_min = 99; rd_max = 0;
  endtask

  task automatic launch(input logic [14:0] base, input int nbytes, input logic tmode,
                        input int plen, input int stall, input logic [7:0] seed);
    clear_stats();
    prog_len = plen; stall_at = stall; src_len = nbytes; src_idx = 0; src_on = 1'b1;
    for (int i = 0; i < 64; i++) src_bytes[i] = seed + 8'(i * 37);
    base_addr = base; len_m1 = 6'(nbytes - 1); poll_toggle = tmode; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R10", "busy after start", busy, 1);
  endtask

  task automatic wait_end();
    for (int i = 0; i < 4000 && (done_n + err_n) == 0; i++) @(negedge clk);
    @(negedge clk);
    src_on = 1'b0;
  endtask

  task automatic kill_model();
    model_kill = 1'b1; @(negedge clk); model_kill = 1'b0; @(negedge clk);
  endtask

  task automatic check_page(input logic [14:0] base, input int nbytes, input string req);
    int bad = 0;
    for (int i = 0; i < nbytes; i++) begin
      logic [14:0] a;
      a = {base[14:6], 6'(base[5:0] + 6'(i))};
      if (mem[a[9:0]] !== src_bytes[i]) bad++;
    end
    check(bad == 0, req, "bytes wrong in memory", bad, 0);
    check(writes == nbytes, req, "write strobes", writes, nbytes);
  endtask

  task automatic t_reset();
    check(busy === 1'b0 && done === 1'b0 && err === 1'b0, "R1", "status after reset",
          {busy, done, err}, 0);
    check(mem_cs_n === 1'b1 && mem_wr_n === 1'b1 && mem_rd_n === 1'b1 && mem_dq_drive === 1'b0,
          "R1", "strobes after reset", {mem_cs_n, mem_wr_n, mem_rd_n, mem_dq_drive}, 4'b1110);
  endtask

  task automatic t_single_data();
    launch(15'h0045, 1, 1'b0, 80, 99, 8'h12);
    wait_end();
    check(done_n == 1 && err_n == 0, "R6", "done/err pulses", done_n * 10 + err_n, 10);
    check_page(15'h0045, 1, "R2");
    check(done_cyc > prog_end_cyc, "R6", "done after programming end", done_cyc, prog_end_cyc + 1);
    check(done_cyc - prog_end_cyc <= 12, "R6", "done latency after programming", done_cyc - prog_end_cyc, 12);
    check(viol_poll_addr == 0, "R6", "poll reads off last address", viol_poll_addr, 0);
    check(busy === 1'b0, "R10", "busy after done", busy, 0);
  endtask

  task automatic t_full_page();
    launch(15'h0083, 64, 1'b0, 60, 99, 8'h80);
    wait_end();
    check(done_n == 1, "R6", "done for full page", done_n, 1);
    check_page(15'h0083, 64, "R2");
    check(viol_page == 0, "R2", "page changed within operation", viol_page, 0);
    check(max_space <= WIN && max_space > 0, "R4", "max load spacing", max_space, WIN);
    check(wr_min == PULSE && wr_max == PULSE, "R3", "write pulse width", wr_max * 100 + wr_min, PULSE * 101);
    check(viol_overlap == 0 && viol_wrprog == 0, "R3", "strobe overlap", viol_overlap + viol_wrprog, 0);
    check(viol_bus == 0, "R5", "bus driven during read", viol_bus, 0);
    check(rd_min == READ && rd_max == READ, "R8", "read pulse width", rd_max * 100 + rd_min, READ * 101);
  endtask

  task automatic t_toggle();
    launch(15'h01C0, 10, 1'b1, 120, 99, 8'h3C);
    wait_end();
    check(done_n == 1 && err_n == 0, "R7", "toggle mode done", done_n * 10 + err_n, 10);
    check_page(15'h01C0, 10, "R2");
    check(done_cyc > prog_end_cyc, "R7", "toggle done after programming end", done_cyc, prog_end_cyc + 1);
    check(done_cyc - prog_end_cyc <= 12, "R7", "toggle done latency", done_cyc - prog_end_cyc, 12);
  endtask

  task automatic t_start_while_busy();
    launch(15'h0100, 5, 1'b0, 50, 99, 8'h55);
    repeat (4) @(negedge clk);
    base_addr = 15'h0300; len_m1 = 6'd20; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_end();
    repeat (20) @(negedge clk);
    check(done_n == 1, "R10", "done pulses for one start", done_n, 1);
    check(mem[10'h300] === 8'hFF, "R10", "ignored start wrote memory", mem[10'h300], 8'hFF);
    check_page(15'h0100, 5, "R10");
  endtask

  task automatic t_timeout();
    launch(15'h0200, 2, 1'b0, 100000, 99, 8'h07);
    wait_end();
    check(err_n == 1 && done_n == 0, "R9", "timeout err/done", err_n * 10 + done_n, 10);
    check(err_cyc - last_fall_cyc >= TMO, "R9", "timeout too early", err_cyc - last_fall_cyc, TMO);
    check(err_cyc - last_fall_cyc <= TMO + 20, "R9", "timeout too late", err_cyc - last_fall_cyc, TMO + 20);
    check(busy === 1'b0, "R9", "busy after timeout", busy, 0);
    kill_model();
  endtask

  task automatic t_starve();
    launch(15'h0280, 8, 1'b1, 40, 3, 8'hA1);
    wait_end();
    check(err_n == 1 && done_n == 0, "R4", "starvation err/done", err_n * 10 + done_n, 10);
    check(writes == 3, "R4", "write strobes before abort", writes, 3);
    repeat (30) @(negedge clk);
    check(writes == 3, "R4", "write strobes after abort", writes, 3);
    check(max_space <= WIN, "R4", "load spacing", max_space, WIN);
    kill_model();
  endtask

  bit finished = 0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog (R1-R10 run): actual %0d cycles expected fewer", 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single_data();
    t_full_page();
    t_toggle();
    t_start_while_busy();
    t_timeout();
    t_starve();
    repeat (5) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule